// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block keeps the interrupt bookkeeping for a two-channel serial controller. Channels are indexed 0 for channel A and 1 for channel B on every per-channel port. Each channel reports single-cycle events: a received byte, the transmit buffer draining, a line break, a host read of the data register, and a host write of the data register. The host also issues two per-channel commands: reset the highest in-service condition, and clear the transmit interrupt.

From these inputs the block tracks receive and transmit pending flags and in-service flags for each channel. It drives one registered, active-high interrupt request shared by both channels. It also publishes a six-bit pending summary and an interrupt vector byte. The vector byte names the channel and the cause of the most recent interrupt change.

A receive condition that is in service holds back the transmit interrupt. The held-back interrupt is not flagged until the receive service ends. A status-high control input selects which bits of the vector carry the cause code.

Top module: `sio_irq_vector`

## Requirements
- R1: A channel requests an interrupt when any of these holds: its transmit enable is set and transmit is pending; its receive mode is 1 (first character) or 2 (all characters) and receive is pending; its break enable is set and its break status is set. Receive modes 0 and 3 never request.
- R2: `irq` is the OR of both channel requests. It is registered, so it reflects the flag state of the previous clock.
- R3: `pendBits` layout is: bit 5 rx A, bit 4 tx A, bit 3 ext A, bit 2 rx B, bit 1 tx B, bit 0 ext B; bits 7:6 are zero. A tx bit is set only when a transmit interrupt is flagged with that channel's transmit enable set. An ext bit equals the break status ANDed with the break enable.
- R4: With `statusHigh` low, the vector codes are: no interrupt 0x06, rx A 0x0C, rx B 0x04, tx A 0x08, tx B 0x00. With `statusHigh` high they are 0x60, 0x30, 0x20, 0x10 and 0x00. When both channels update the vector in one cycle, channel A's code wins.
- R5: A received byte sets receive-available, rx pending and rx in-service, and loads the channel's rx vector code.
- R6: A transmit-empty event sets the tx-empty status and tx pending. It sets tx in-service, the tx pending bit and the tx vector code only when rx in-service is clear.
- R7: Reset-highest-in-service does the following. If rx in-service is set, it clears that flag and re-raises a pending transmit interrupt, which flags tx service and loads the tx vector. Otherwise it clears tx in-service.
- R8: A data read clears receive-available, rx pending and rx in-service, and loads the no-interrupt code. If tx is pending, the transmit interrupt is re-raised instead.
- R9: Clear-transmit-interrupt clears tx pending, tx in-service and the tx pending bit, and loads the no-interrupt code. If rx is pending, the receive interrupt is re-raised: rx in-service is set and the rx code is loaded.
- R10: A data write clears tx pending and the tx-empty status, which drops that channel's transmit request.
- R11: A break event sets the channel's break status, which stays set until reset.
- R12: After reset all flags and pending bits are zero, `txEmpty` is 2'b11, the vector is 0x06 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statusHigh | input | 1 | Select the high cause field of the vector |
| txIntEn | input | 2 | Transmit interrupt enable per channel |
| rxIntMode | input | 4 | Receive mode; [1:0] channel A, [3:2] channel B |
| brkIntEn | input | 2 | Break interrupt enable per channel |
| rxByteEvt | input | 2 | Received byte available, one cycle |
| txEmptyEvt | input | 2 | Transmit buffer drained, one cycle |
| brkEvt | input | 2 | Break detected, one cycle |
| dataRdEvt | input | 2 | Host read of the data register, one cycle |
| dataWrEvt | input | 2 | Host write of the data register, one cycle |
| rstIusCmd | input | 2 | Reset-highest-in-service command |
| clrTxCmd | input | 2 | Clear-transmit-interrupt command |
| irq | output | 1 | Shared interrupt request, active high |
| pendBits | output | 8 | Pending summary |
| vector | output | 8 | Interrupt vector byte |
| rxAvail | output | 2 | Receive character available |
| txEmpty | output | 2 | Transmit buffer empty |
| brkStat | output | 2 | Break status |

## Verification
The properties assume that each channel sees at most one event or command per cycle. The control does apply a fixed priority when strobes coincide, but the checks on receive entry and on a held-back transmit interrupt only cover a cycle where a single strobe is active. The stimulus respects this by pulsing one strobe per task step and letting the flags settle before the next one. The only exception is the case where both channels receive in the same cycle, which is one event on each channel. Configuration inputs change only between steps, so the registered request never sees an enable change in the same cycle as an event.

// File: rtl/sivc_pkg.sv
package sivc_pkg;
  localparam int NUM_CH = 2;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {CAUSE_NONE, CAUSE_RX, CAUSE_TX} cause_e;

  typedef struct packed {
    logic rxPend;
    logic rxIus;
    logic rxAvail;
    logic txPend;
    logic txIus;
    logic txFlag;
    logic txEmpty;
    logic brk;
  } chFlags_t;

  typedef struct packed {
    logic   setRx;
    logic   clrRx;
    logic   clrRxIus;
    logic   raiseRxSvc;
    logic   setTxPend;
    logic   clrTx;
    logic   clrTxIus;
    logic   raiseTxSvc;
    logic   txFlagOn;
    logic   dropTxPend;
    logic   setEmpty;
    logic   setBrk;
    logic   vecLoad;
    cause_e vecCause;
  } chStrobe_t;

  // Cause code: bit2 marks channel A, bits1:0 give the kind.
  function automatic logic [CODE_W-1:0] causeCode(cause_e c, logic isA);
    case (c)
      CAUSE_RX: causeCode = {isA, 2'b10};
      CAUSE_TX: causeCode = {isA, 2'b00};
      default:  causeCode = 3'b011;
    endcase
  endfunction

  // Low field sits at bits 3:1; high field holds the code reversed at bits 6:4.
  function automatic logic [VEC_W-1:0] placeCode(logic [CODE_W-1:0] c, logic hi);
    if (hi) placeCode = {1'b0, c[0], c[1], c[2], 4'b0000};
    else    placeCode = {4'b0000, c, 1'b0};
  endfunction
endpackage

// File: rtl/sio_irq_vector_ctrl.sv
module sio_irq_vector_ctrl
  import sivc_pkg::*;
(
  input  logic      rxByteEvt,
  input  logic      txEmptyEvt,
  input  logic      brkEvt,
  input  logic      dataRdEvt,
  input  logic      dataWrEvt,
  input  logic      rstIusCmd,
  input  logic      clrTxCmd,
  input  logic      txIntEn,
  input  logic      rxPend,
  input  logic      rxIus,
  input  logic      txPend,
  output chStrobe_t strb
);
  always_comb begin
    strb          = '0;
    strb.vecCause = CAUSE_NONE;
    strb.txFlagOn = txIntEn;
    strb.setBrk   = brkEvt;
    if (dataRdEvt) begin
      strb.clrRx   = 1'b1;
      strb.vecLoad = 1'b1;
      if (txPend) begin
        strb.raiseTxSvc = 1'b1;
        strb.vecCause   = CAUSE_TX;
      end
    end else if (clrTxCmd) begin
      strb.clrTx   = 1'b1;
      strb.vecLoad = 1'b1;
      if (rxPend) begin
        strb.raiseRxSvc = 1'b1;
        strb.vecCause   = CAUSE_RX;
      end
    end else if (rstIusCmd) begin
      if (rxIus) begin
        strb.clrRxIus = 1'b1;
        if (txPend) begin
          strb.raiseTxSvc = 1'b1;
          strb.vecLoad    = 1'b1;
          strb.vecCause   = CAUSE_TX;
        end
      end else begin
        strb.clrTxIus = 1'b1;
      end
    end else if (rxByteEvt) begin
      strb.setRx    = 1'b1;
      strb.vecLoad  = 1'b1;
      strb.vecCause = CAUSE_RX;
    end else if (txEmptyEvt) begin
      strb.setEmpty  = 1'b1;
      strb.setTxPend = 1'b1;
      if (!rxIus) begin
        strb.raiseTxSvc = 1'b1;
        strb.vecLoad    = 1'b1;
        strb.vecCause   = CAUSE_TX;
      end
    end else if (dataWrEvt) begin
      strb.dropTxPend = 1'b1;
    end
  end
endmodule

// File: rtl/sio_irq_vector_dp.sv
module sio_irq_vector_dp
  import sivc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      statusHigh,
  input  logic [NUM_CH-1:0]         txIntEn,
  input  logic [2*NUM_CH-1:0]       rxIntMode,
  input  logic [NUM_CH-1:0]         brkIntEn,
  input  chStrobe_t [NUM_CH-1:0]    strb,
  output chFlags_t  [NUM_CH-1:0]    flags,
  output logic                      irq,
  output logic [VEC_W-1:0]          pendBits,
  output logic [VEC_W-1:0]          vector
);
  localparam logic [VEC_W-1:0] VEC_RST = 8'h06;

  chFlags_t [NUM_CH-1:0] flagQ;
  logic [VEC_W-1:0]      vecQ, vecNext;
  logic [NUM_CH-1:0]     chReq, extBit;
  logic                  irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        flagQ[c]         <= '0;
        flagQ[c].txEmpty <= 1'b1;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (strb[c].clrRx)      flagQ[c].rxPend <= 1'b0;
        else if (strb[c].setRx) flagQ[c].rxPend <= 1'b1;

        if (strb[c].clrRx || strb[c].clrRxIus)           flagQ[c].rxIus <= 1'b0;
        else if (strb[c].setRx || strb[c].raiseRxSvc)    flagQ[c].rxIus <= 1'b1;

        if (strb[c].clrRx)      flagQ[c].rxAvail <= 1'b0;
        else if (strb[c].setRx) flagQ[c].rxAvail <= 1'b1;

        if (strb[c].clrTx || strb[c].dropTxPend) flagQ[c].txPend <= 1'b0;
        else if (strb[c].setTxPend)              flagQ[c].txPend <= 1'b1;

        if (strb[c].clrTx || strb[c].clrTxIus) flagQ[c].txIus <= 1'b0;
        else if (strb[c].raiseTxSvc)           flagQ[c].txIus <= 1'b1;

        if (strb[c].clrTx)           flagQ[c].txFlag <= 1'b0;
        else if (strb[c].raiseTxSvc) flagQ[c].txFlag <= flagQ[c].txFlag | strb[c].txFlagOn;

        if (strb[c].dropTxPend)    flagQ[c].txEmpty <= 1'b0;
        else if (strb[c].setEmpty) flagQ[c].txEmpty <= 1'b1;

        if (strb[c].setBrk) flagQ[c].brk <= 1'b1;
      end
    end
  end

  // Later iterations override earlier ones, so channel A (index 0) is applied last and wins.
  always_comb begin
    vecNext = vecQ;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (strb[c].vecLoad)
        vecNext = placeCode(causeCode(strb[c].vecCause, c == 0), statusHigh);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) vecQ <= VEC_RST;
    else       vecQ <= vecNext;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gReq
      logic rxModeOn;
      assign rxModeOn = (rxIntMode[2*g +: 2] == 2'd1) || (rxIntMode[2*g +: 2] == 2'd2);
      assign chReq[g] = (txIntEn[g] & flagQ[g].txPend) |
                        (rxModeOn & flagQ[g].rxPend) |
                        (brkIntEn[g] & flagQ[g].brk);
      assign extBit[g] = brkIntEn[g] & flagQ[g].brk;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |chReq;
  end

  assign pendBits = {2'b00,
                     flagQ[0].rxPend, flagQ[0].txFlag, extBit[0],
                     flagQ[1].rxPend, flagQ[1].txFlag, extBit[1]};
  assign flags  = flagQ;
  assign irq    = irqQ;
  assign vector = vecQ;

  assert_vector_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    vecQ inside {8'h06, 8'h0C, 8'h04, 8'h08, 8'h00, 8'h60, 8'h30, 8'h20, 8'h10});

  generate
    for (g = 0; g < NUM_CH; g++) begin : gChk
      assert_rxius_needs_pend_R5: assert property (@(posedge clk) disable iff (!rstN)
        flagQ[g].rxIus |-> flagQ[g].rxPend);
      assert_txflag_needs_ius_R3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(flagQ[g].txFlag) |-> flagQ[g].txIus);
    end
  endgenerate
endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
  import sivc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       statusHigh,
  input  logic [1:0] txIntEn,
  input  logic [3:0] rxIntMode,
  input  logic [1:0] brkIntEn,
  input  logic [1:0] rxByteEvt,
  input  logic [1:0] txEmptyEvt,
  input  logic [1:0] brkEvt,
  input  logic [1:0] dataRdEvt,
  input  logic [1:0] dataWrEvt,
  input  logic [1:0] rstIusCmd,
  input  logic [1:0] clrTxCmd,
  output logic       irq,
  output logic [7:0] pendBits,
  output logic [7:0] vector,
  output logic [1:0] rxAvail,
  output logic [1:0] txEmpty,
  output logic [1:0] brkStat
);
  chStrobe_t [NUM_CH-1:0] strb;
  chFlags_t  [NUM_CH-1:0] flags;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gCh
      sio_irq_vector_ctrl uCtrl (
        .rxByteEvt (rxByteEvt[g]),
        .txEmptyEvt(txEmptyEvt[g]),
        .brkEvt    (brkEvt[g]),
        .dataRdEvt (dataRdEvt[g]),
        .dataWrEvt (dataWrEvt[g]),
        .rstIusCmd (rstIusCmd[g]),
        .clrTxCmd  (clrTxCmd[g]),
        .txIntEn   (txIntEn[g]),
        .rxPend    (flags[g].rxPend),
        .rxIus     (flags[g].rxIus),
        .txPend    (flags[g].txPend),
        .strb      (strb[g])
      );
      assign rxAvail[g] = flags[g].rxAvail;
      assign txEmpty[g] = flags[g].txEmpty;
      assign brkStat[g] = flags[g].brk;

      assert_rx_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
        (rxByteEvt[g] && !dataRdEvt[g] && !clrTxCmd[g] && !rstIusCmd[g])
        |=> (flags[g].rxAvail && flags[g].rxPend && flags[g].rxIus));
      assert_tx_held_R6: assert property (@(posedge clk) disable iff (!rstN)
        (txEmptyEvt[g] && flags[g].rxIus && !rxByteEvt[g] && !dataRdEvt[g] &&
         !clrTxCmd[g] && !rstIusCmd[g]) |=> $stable(flags[g].txIus));
      assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
        dataRdEvt[g] |=> !flags[g].rxAvail);
    end
  endgenerate

  sio_irq_vector_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .statusHigh(statusHigh),
    .txIntEn   (txIntEn),
    .rxIntMode (rxIntMode),
    .brkIntEn  (brkIntEn),
    .strb      (strb),
    .flags     (flags),
    .irq       (irq),
    .pendBits  (pendBits),
    .vector    (vector)
  );

  assert_quiet_irq_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!flags[0].rxPend && !flags[0].txPend && !flags[0].brk &&
     !flags[1].rxPend && !flags[1].txPend && !flags[1].brk) |=> !irq);
endmodule

// File: tb/sio_irq_vector_test.sv
module sio_irq_vector_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN;
  logic       statusHigh;
  logic [1:0] txIntEn, brkIntEn;
  logic [3:0] rxIntMode;
  logic [1:0] rxByteEvt, txEmptyEvt, brkEvt, dataRdEvt, dataWrEvt, rstIusCmd, clrTxCmd;
  logic       irq;
  logic [7:0] pendBits, vector;
  logic [1:0] rxAvail, txEmpty, brkStat;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  localparam int K_RX = 0, K_TX = 1, K_BRK = 2, K_RD = 3, K_WR = 4, K_IUS = 5, K_CLRTX = 6;

  sio_irq_vector uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // Pulse one strobe kind on the channels in m, then let flags and irq settle.
  task automatic fire(int kind, logic [1:0] m);
    @(negedge clk);
    case (kind)
      K_RX:    rxByteEvt  = m;
      K_TX:    txEmptyEvt = m;
      K_BRK:   brkEvt     = m;
      K_RD:    dataRdEvt  = m;
      K_WR:    dataWrEvt  = m;
      K_IUS:   rstIusCmd  = m;
      default: clrTxCmd   = m;
    endcase
    @(negedge clk);
    {rxByteEvt, txEmptyEvt, brkEvt, dataRdEvt, dataWrEvt, rstIusCmd, clrTxCmd} = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 pend", pendBits, 8'h00);
    check("R12 vector", vector, 8'h06);
    check("R12 irq", {7'd0, irq}, 8'h00);
    check("R12 txEmpty", {6'd0, txEmpty}, 8'h03);
    check("R12 rxAvail", {6'd0, rxAvail}, 8'h00);
  endtask

  task automatic t_rx_basic();
    txIntEn = 2'b00; rxIntMode = 4'b0001; settle();
    @(negedge clk); rxByteEvt = 2'b01;
    @(negedge clk); rxByteEvt = 2'b00;
    check("R2 irq lags one cycle", {7'd0, irq}, 8'h00);
    check("R5 rxAvail", {6'd0, rxAvail}, 8'h01);
    @(negedge clk);
    check("R2 irq raised", {7'd0, irq}, 8'h01);
    check("R3 pend rxA", pendBits, 8'h20);
    check("R4 vector rxA", vector, 8'h0C);
    fire(K_RD, 2'b01);
    check("R8 rxAvail cleared", {6'd0, rxAvail}, 8'h00);
    check("R8 pend", pendBits, 8'h00);
    check("R8 vector", vector, 8'h06);
    check("R8 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_status_high();
    statusHigh = 1'b1; rxIntMode = 4'b0100;
    fire(K_RX, 2'b10);
    check("R4 high rxB", vector, 8'h20);
    check("R3 pend rxB", pendBits, 8'h04);
    check("R2 irq from B", {7'd0, irq}, 8'h01);
    fire(K_RD, 2'b10);
    check("R4 high none", vector, 8'h60);
    statusHigh = 1'b0;
  endtask

  task automatic t_tx_held();
    txIntEn = 2'b01; rxIntMode = 4'b0001; settle();
    fire(K_RX, 2'b01);
    fire(K_TX, 2'b01);
    check("R6 tx held pend", pendBits, 8'h20);
    check("R6 tx held vector", vector, 8'h0C);
    fire(K_IUS, 2'b01);
    check("R7 reraise pend", pendBits, 8'h30);
    check("R7 reraise vector", vector, 8'h08);
    fire(K_RD, 2'b01);
    check("R8 tx reraised pend", pendBits, 8'h10);
    check("R8 tx reraised vector", vector, 8'h08);
    check("R1 tx request", {7'd0, irq}, 8'h01);
    fire(K_CLRTX, 2'b01);
    check("R9 pend", pendBits, 8'h00);
    check("R9 vector", vector, 8'h06);
    check("R9 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_clrtx_reraise_rx();
    txIntEn = 2'b00; rxIntMode = 4'b0100; settle();
    fire(K_RX, 2'b10);
    fire(K_TX, 2'b10);
    fire(K_CLRTX, 2'b10);
    check("R9 rx reraised vector", vector, 8'h04);
    check("R9 rx reraised pend", pendBits, 8'h04);
    fire(K_RD, 2'b10);
    check("R8 vector B", vector, 8'h06);
  endtask

  task automatic t_data_write();
    txIntEn = 2'b01; rxIntMode = 4'b0000; settle();
    fire(K_TX, 2'b01);
    check("R6 tx pend", pendBits, 8'h10);
    check("R6 tx vector", vector, 8'h08);
    check("R6 irq", {7'd0, irq}, 8'h01);
    fire(K_WR, 2'b01);
    check("R10 txEmpty low", {6'd0, txEmpty}, 8'h02);
    check("R10 irq dropped", {7'd0, irq}, 8'h00);
    fire(K_TX, 2'b01);
    check("R6 txEmpty back", {6'd0, txEmpty}, 8'h03);
    check("R6 irq back", {7'd0, irq}, 8'h01);
    fire(K_CLRTX, 2'b01);
    check("R9 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rx_modes();
    txIntEn = 2'b00; rxIntMode = 4'b0011; settle();
    fire(K_RX, 2'b01);
    check("R1 mode3 no irq", {7'd0, irq}, 8'h00);
    rxIntMode = 4'b0010; settle();
    check("R1 mode2 irq", {7'd0, irq}, 8'h01);
    rxIntMode = 4'b0000; settle();
    check("R1 mode0 no irq", {7'd0, irq}, 8'h00);
    fire(K_RD, 2'b01);
  endtask

  task automatic t_tx_disabled();
    txIntEn = 2'b00; rxIntMode = 4'b0000; settle();
    fire(K_TX, 2'b10);
    check("R3 txB bit needs enable", pendBits, 8'h00);
    check("R4 vector txB", vector, 8'h00);
    check("R1 tx disabled", {7'd0, irq}, 8'h00);
    fire(K_CLRTX, 2'b10);
    check("R9 vector", vector, 8'h06);
  endtask

  task automatic t_both_rx();
    rxIntMode = 4'b0101; settle();
    fire(K_RX, 2'b11);
    check("R4 A wins", vector, 8'h0C);
    check("R3 both rx", pendBits, 8'h24);
    fire(K_RD, 2'b01);
    fire(K_RD, 2'b10);
    check("R8 both read", pendBits, 8'h00);
    rxIntMode = 4'b0000;
  endtask

  task automatic t_break();
    brkIntEn = 2'b00; settle();
    fire(K_BRK, 2'b10);
    check("R11 brk status", {6'd0, brkStat}, 8'h02);
    check("R3 ext masked", pendBits, 8'h00);
    check("R1 brk masked", {7'd0, irq}, 8'h00);
    brkIntEn = 2'b11; settle();
    check("R3 extB", pendBits, 8'h01);
    check("R1 brk irq", {7'd0, irq}, 8'h01);
    fire(K_BRK, 2'b01);
    check("R11 sticky", {6'd0, brkStat}, 8'h03);
    check("R3 extA extB", pendBits, 8'h09);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; statusHigh = 1'b0; txIntEn = '0; rxIntMode = '0; brkIntEn = '0;
    {rxByteEvt, txEmptyEvt, brkEvt, dataRdEvt, dataWrEvt, rstIusCmd, clrTxCmd} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_status_high();
    t_tx_held();
    t_clrtx_reraise_rx();
    t_data_write();
    t_rx_modes();
    t_tx_disabled();
    t_both_rx();
    t_break();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule